// File: doc/BRIEF.md
# Mantissa-Exponent Token-Bucket Rate Shaper

This block is one shaping stage of a transmit scheduler. It holds a credit counter, in units of 1/256 byte, that a periodic time wheel refills and that each granted packet drains by its byte length. One 64-bit configuration word sets both the refill amount and the bucket depth. Each is a small floating-point number: an 8-bit mantissa with an implied leading 256 and a 4-bit exponent. A divider exponent stretches the refill period. The period's base count depends on whether the stage sits at the top scheduling level (240 clock ticks by default) or at any lower level (860 ticks by default).

Packets arrive on a valid/ready stream that carries their byte length. The stage raises `req_ready` whenever the credit is not negative, so one packet may overdraw the bucket. `req_ready` comes only from registered state and never from `req_valid`. A requester that sees ready low keeps `req_valid` and `req_len` steady until the handshake. A transfer takes place on a clock edge where both are high. When the configuration does not enable shaping, every request passes and the credit sits at full depth. The signed credit is visible on a status output.

Top module: `rate_shaper`

## Requirements
- R1: The configuration word has these fields: enable at bit 0, rate mantissa at bits 8:1, rate exponent at bits 12:9, divider exponent at bits 16:13, burst mantissa at bits 36:29 and burst exponent at bits 40:37. Shaping is active only when enable is 1, at least one rate field (mantissa, exponent, divider) is nonzero and at least one burst field is nonzero.
- R2: A cycle with `cfg_we` high stores the word. On that edge the credit becomes the new depth, which is ((256 + burst mantissa) << (burst exponent + 1)) in 1/256-byte units. A handshake in that same cycle is not debited.
- R3: The refill period is P = T << div cycles. T is TICKS_TOP when `top_level` is 1 and TICKS_LOW otherwise. A configuration write restarts the wheel, so the first refill lands on the P-th edge after the write edge.
- R4: Each refill adds (256 + rate mantissa) << rate exponent to the credit. The credit never exceeds the depth.
- R5: While shaping is active, `req_ready` is 1 exactly when the signed credit is zero or above. A handshake subtracts `req_len` × 256 on its edge. A request held with ready low leaves the credit unchanged.
- R6: When a refill and a handshake fall on the same edge, both are applied, and the sum is then clipped at the depth.
- R7: While shaping is inactive, `req_ready` stays 1 and the credit equals the depth on every cycle, whatever requests arrive.
- R8: After reset the stored word is zero, shaping is inactive, `req_ready` is 1 and the credit is 512.
- R9: A divider exponent above 12 acts as 12.
- R10: The credit never falls below -(2^LEN_W - 1) × 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 64 | Configuration word (fields in R1) |
| top_level | input | 1 | 1 selects the top-level wheel resolution |
| req_valid | input | 1 | Packet request valid |
| req_len | input | LEN_W | Packet length in bytes |
| req_ready | output | 1 | Grant; a transfer occurs when valid and ready are both high |
| credit_level | output | CRED_W | Signed credit in 1/256-byte units |

## Verification
The wheel refill and a packet debit can land on the same clock edge. When that happens, the add, the subtract and the clip at depth must combine in a single step. The bench provokes this by holding `req_valid` high without a break while wheel periods are only a few cycles long, so handshakes and refills overlap again and again. This is done for both level selects and for shallow and deeper buckets. A model in the bench applies both updates and then clips. It compares its result, and the ready it predicts, with the ports on every cycle.

// File: rtl/shp_pkg.sv
package shp_pkg;
  localparam int MANT_W     = 8;
  localparam int EXP_W      = 4;
  localparam int DIV_W      = 4;
  localparam int DIV_LIMIT  = 12;
  localparam int FRAC_W     = 8;
  localparam int POS_EN     = 0;
  localparam int POS_RMANT  = 1;
  localparam int POS_REXP   = 9;
  localparam int POS_RDIV   = 13;
  localparam int POS_BMANT  = 29;
  localparam int POS_BEXP   = 37;
  localparam int REFILL_W   = MANT_W + (1 << EXP_W);
  localparam int DEPTH_W    = MANT_W + 1 + (1 << EXP_W);
  localparam int IDLE_DEPTH = 1 << (FRAC_W + 1);

  typedef struct packed {
    logic              en;
    logic [MANT_W-1:0] rmant;
    logic [EXP_W-1:0]  rexp;
    logic [DIV_W-1:0]  rdiv;
    logic [MANT_W-1:0] bmant;
    logic [EXP_W-1:0]  bexp;
  } shp_cfg_t;

  function automatic shp_cfg_t unpack_cfg(input logic [63:0] w);
    shp_cfg_t c;
    c.en    = w[POS_EN];
    c.rmant = w[POS_RMANT +: MANT_W];
    c.rexp  = w[POS_REXP +: EXP_W];
    c.rdiv  = w[POS_RDIV +: DIV_W];
    c.bmant = w[POS_BMANT +: MANT_W];
    c.bexp  = w[POS_BEXP +: EXP_W];
    return c;
  endfunction

  function automatic logic shaping_on(input shp_cfg_t c);
    return c.en && (|{c.rmant, c.rexp, c.rdiv}) && (|{c.bmant, c.bexp});
  endfunction

  function automatic logic [DEPTH_W-1:0] depth_of(input shp_cfg_t c);
    logic [DEPTH_W-1:0] base;
    base = DEPTH_W'({1'b1, c.bmant});
    return base << ({1'b0, c.bexp} + 5'd1);
  endfunction

  function automatic logic [REFILL_W-1:0] refill_of(input shp_cfg_t c);
    logic [REFILL_W-1:0] base;
    base = REFILL_W'({1'b1, c.rmant});
    return base << c.rexp;
  endfunction

  function automatic int cred_width(input int len_w);
    int a;
    a = len_w + FRAC_W;
    return ((a > DEPTH_W) ? a : DEPTH_W) + 2;
  endfunction
endpackage

// File: rtl/shp_cfg_reg.sv
module shp_cfg_reg
  import shp_pkg::*;
#(
  parameter int CRED_W = 27
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [63:0]              cfg_word,
  output logic                     active,
  output logic [DIV_W-1:0]         div_eff,
  output logic signed [CRED_W-1:0] depth,
  output logic signed [CRED_W-1:0] refill,
  output logic signed [CRED_W-1:0] load_depth
);
  shp_cfg_t cur;
  shp_cfg_t nxt;

  assign nxt = unpack_cfg(cfg_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= '0;
    else if (cfg_we) cur <= nxt;
  end

  assign active     = shaping_on(cur);
  assign div_eff    = (cur.rdiv > DIV_W'(DIV_LIMIT)) ? DIV_W'(DIV_LIMIT) : cur.rdiv;
  assign depth      = CRED_W'(depth_of(cur));
  assign refill     = CRED_W'(refill_of(cur));
  assign load_depth = CRED_W'(depth_of(nxt));
endmodule

// File: rtl/shp_tick.sv
module shp_tick
  import shp_pkg::*;
#(
  parameter int T_TOP = 240,
  parameter int T_LOW = 860
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             top_level,
  input  logic [DIV_W-1:0] div_eff,
  output logic             tick
);
  localparam int T_MAX = (T_TOP > T_LOW) ? T_TOP : T_LOW;
  localparam int CNT_W = $clog2(T_MAX << DIV_LIMIT) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;

  assign period = CNT_W'(top_level ? T_TOP : T_LOW) << div_eff;
  assign tick   = (cnt >= (period - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cfg_we) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/shp_bucket.sv
module shp_bucket
  import shp_pkg::*;
#(
  parameter int CRED_W = 27,
  parameter int LEN_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     active,
  input  logic                     tick,
  input  logic signed [CRED_W-1:0] depth,
  input  logic signed [CRED_W-1:0] refill,
  input  logic signed [CRED_W-1:0] load_depth,
  input  logic                     req_valid,
  input  logic [LEN_W-1:0]         req_len,
  output logic                     req_ready,
  output logic signed [CRED_W-1:0] credit
);
  logic signed [CRED_W-1:0] add_amt;
  logic signed [CRED_W-1:0] sub_amt;
  logic signed [CRED_W-1:0] sum;
  logic                     fire;

  assign req_ready = !active || !credit[CRED_W-1];
  assign fire      = req_valid && req_ready;
  assign add_amt   = tick ? refill : '0;
  assign sub_amt   = fire ? CRED_W'({req_len, {FRAC_W{1'b0}}}) : '0;
  assign sum       = credit + add_amt - sub_amt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           credit <= CRED_W'(IDLE_DEPTH);
    else if (cfg_we)      credit <= load_depth;
    else if (!active)     credit <= depth;
    else if (sum > depth) credit <= depth;
    else                  credit <= sum;
  end
endmodule

// File: rtl/rate_shaper.sv
module rate_shaper
  import shp_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int TICKS_TOP = 240,
  parameter int TICKS_LOW = 860,
  localparam int CRED_W   = cred_width(LEN_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [63:0]              cfg_word,
  input  logic                     top_level,
  input  logic                     req_valid,
  input  logic [LEN_W-1:0]         req_len,
  output logic                     req_ready,
  output logic signed [CRED_W-1:0] credit_level
);
  logic                     act_w;
  logic                     tick_w;
  logic [DIV_W-1:0]         div_w;
  logic signed [CRED_W-1:0] depth_w;
  logic signed [CRED_W-1:0] refill_w;
  logic signed [CRED_W-1:0] load_w;

  shp_cfg_reg #(.CRED_W(CRED_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .active(act_w), .div_eff(div_w), .depth(depth_w), .refill(refill_w),
    .load_depth(load_w)
  );

  shp_tick #(.T_TOP(TICKS_TOP), .T_LOW(TICKS_LOW)) u_tick (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .top_level(top_level),
    .div_eff(div_w), .tick(tick_w)
  );

  shp_bucket #(.CRED_W(CRED_W), .LEN_W(LEN_W)) u_bucket (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .active(act_w), .tick(tick_w),
    .depth(depth_w), .refill(refill_w), .load_depth(load_w),
    .req_valid(req_valid), .req_len(req_len), .req_ready(req_ready),
    .credit(credit_level)
  );
endmodule

// File: rtl/shp_chk.sv
module shp_chk #(
  parameter int CRED_W = 27,
  parameter int LEN_W  = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic                     req_valid,
  input logic [LEN_W-1:0]         req_len,
  input logic                     req_ready,
  input logic                     tick,
  input logic                     active,
  input logic signed [CRED_W-1:0] depth,
  input logic signed [CRED_W-1:0] credit
);
  localparam longint FLOOR = -(((longint'(1) << LEN_W) - 1) << 8);

  assert_load_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> credit == depth);

  assert_cap_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> credit <= depth);

  assert_debit_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && req_valid && req_ready && !tick && !cfg_we)
      |=> credit == $past(credit) - (CRED_W'($past(req_len)) << 8));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && req_valid && !req_ready && !tick && !cfg_we) |=> $stable(credit));

  assert_idle_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cfg_we) |=> credit == depth);

  assert_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    longint'(credit) >= FLOOR);
endmodule

bind rate_shaper shp_chk #(.CRED_W(CRED_W), .LEN_W(LEN_W)) u_shp_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .req_valid(req_valid),
  .req_len(req_len), .req_ready(req_ready), .tick(tick_w), .active(act_w),
  .depth(depth_w), .credit(credit_level)
);

// File: tb/rate_shaper_bench.sv
`timescale 1ns/1ps
module rate_shaper_bench;
  import shp_pkg::*;
  localparam int LEN_W = 8;
  localparam int TT    = 3;
  localparam int TL    = 5;
  localparam int CW    = cred_width(LEN_W);

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, top_level = 1'b0, req_valid = 1'b0;
  logic [63:0] cfg_word = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready;
  logic signed [CW-1:0] credit_level;

  int errors = 0, checks = 0, seed = 0;
  string tag = "R8";
  bit live = 1'b0;
  longint m_cred = 512, m_depth = 512, m_refill = 256, m_cnt = 0;
  int m_div = 0;
  bit m_act = 1'b0;

  always #2.5 clk = ~clk;

  rate_shaper #(.LEN_W(LEN_W), .TICKS_TOP(TT), .TICKS_LOW(TL)) u_rate_shaper (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .top_level(top_level), .req_valid(req_valid), .req_len(req_len),
    .req_ready(req_ready), .credit_level(credit_level)
  );

  function automatic logic [63:0] mk(int en, int rm, int re, int rd, int bm, int be);
    return 64'(en) | (64'(rm) << 1) | (64'(re) << 9) | (64'(rd) << 13)
         | (64'(bm) << 29) | (64'(be) << 37);
  endfunction

  function automatic longint depth_ref(logic [63:0] w);
    return longint'(256 + int'(w[36:29])) * (longint'(1) << (int'(w[40:37]) + 1));
  endfunction

  task automatic check(string t, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // Reference model, updated on each rising edge from the requirement arithmetic
  always @(posedge clk) begin
    longint per, s;
    bit tk, fire;
    if (!rst_n) begin
      m_cred = 512; m_depth = 512; m_refill = 256; m_cnt = 0; m_div = 0; m_act = 0;
    end else begin
      per  = longint'(top_level ? TT : TL) * (longint'(1) << ((m_div > 12) ? 12 : m_div));
      tk   = (m_cnt >= per - 1);
      fire = req_valid && (!m_act || m_cred >= 0);
      if (cfg_we) begin
        m_act    = cfg_word[0] && (cfg_word[16:1] != 0) && (cfg_word[40:29] != 0);
        m_depth  = depth_ref(cfg_word);
        m_refill = longint'(256 + int'(cfg_word[8:1])) * (longint'(1) << int'(cfg_word[12:9]));
        m_div    = int'(cfg_word[16:13]);
        m_cred   = m_depth;
        m_cnt    = 0;
      end else begin
        m_cnt = tk ? 0 : m_cnt + 1;
        if (!m_act) m_cred = m_depth;
        else begin
          s = m_cred + (tk ? m_refill : 0) - (fire ? longint'(req_len) * 256 : 0);
          m_cred = (s > m_depth) ? m_depth : s;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      check(tag, longint'(req_ready), longint'(!m_act || m_cred >= 0), "ready");
      check(tag, longint'(credit_level), m_cred, "credit");
      check("R10", longint'(credit_level >= -(255 * 256) && credit_level <= m_depth), 1, "bounds");
    end
  end

  task automatic apply_cfg(logic [63:0] w);
    req_valid = 1'b0;
    cfg_word  = w;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R2", longint'(credit_level), depth_ref(w), "load depth");
  endtask

  task automatic traffic(int n, bit solid);
    for (int c = 0; c < n; c++) begin
      req_valid = solid ? 1'b1 : (((c + seed) % 3) != 0);
      req_len   = LEN_W'(((c * 37 + seed * 11) % 23) + 1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    seed++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8", longint'(req_ready), 1, "ready in reset");
    check("R8", longint'(credit_level), 512, "credit in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", longint'(credit_level), 512, "credit after reset");
    live = 1'b1;

    // Sweep of small configurations under mixed traffic
    for (int be = 0; be < 4; be++)
      for (int bi = 0; bi < 3; bi++)
        for (int re = 0; re < 3; re++)
          for (int ri = 0; ri < 2; ri++)
            for (int rd = 0; rd < 2; rd++)
              for (int lv = 0; lv < 2; lv++) begin
                int bm, rm;
                bm = (bi == 0) ? 0 : ((bi == 1) ? 128 : 255);
                rm = ri * 255;
                top_level = lv[0];
                if ((rm == 0 && re == 0 && rd == 0) || (bm == 0 && be == 0)) tag = "R1";
                else if (lv == 1) tag = "R3";
                else tag = "R4";
                apply_cfg(mk(1, rm, re, rd, bm, be));
                traffic(30, 1'b0);
              end

    // Refill and debit landing on the same edge
    tag = "R6";
    for (int be = 0; be < 2; be++)
      for (int ri = 0; ri < 2; ri++)
        for (int re = 0; re < 3; re += 2)
          for (int lv = 0; lv < 2; lv++) begin
            top_level = lv[0];
            apply_cfg(mk(1, ri * 255, re, 0, 200, be));
            traffic(40, 1'b1);
          end

    // Shaping disabled: everything passes, credit pinned at depth
    tag = "R7";
    apply_cfg(mk(0, 10, 2, 1, 77, 2));
    traffic(60, 1'b1);
    check("R7", longint'(credit_level), depth_ref(mk(0, 10, 2, 1, 77, 2)), "idle depth");

    // Divider exponent above the limit
    tag = "R9";
    top_level = 1'b1;
    apply_cfg(mk(1, 0, 0, 15, 1, 0));
    req_valid = 1'b1; req_len = LEN_W'(3);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", longint'(credit_level), 514 - 768, "overdraw");
    repeat ((TT << 12) - 2) @(negedge clk);
    check("R9", longint'(req_ready), 0, "before clamped tick");
    repeat (2) @(negedge clk);
    check("R9", longint'(credit_level), 2, "after clamped tick");
    check("R9", longint'(req_ready), 1, "ready after tick");

    live = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule